// File: doc/BRIEF.md
# Staged Coefficient Register Page

This block is one byte-addressed page of 32-bit filter and mixer coefficients behind a byte-wide host register bus. It keeps four mixer gains and the three coefficients of a first-order IIR section (two numerator terms and one denominator term). Each coefficient occupies four consecutive byte addresses, and the lowest of the four carries the most significant byte. The whole set is presented in parallel to the audio datapath. An 8-bit page-select byte sits at address 0x00 and is passed out for an outer decoder.

Host writes do not touch a live coefficient byte by byte. Each byte lands in a staging register, and the 32-bit value moves into the live coefficient in one step. That happens only when the four bytes of one coefficient arrive in order, starting from its top byte. Any other write pattern drops the staged value. This keeps the datapath from ever seeing a half-updated gain.

Reads come back as a burst that starts at an address and then advances one byte per request. A read issued from the SPI-side front end begins with one filler byte, so a coefficient read takes five bytes on that path.

Top module: `coef_bank`

## Requirements
- R1: After reset, coefficients 0 (mixer A in 1), 3 (mixer B in 2) and 4 (IIR numerator 0) read 0x7FFFFFFF, coefficients 1, 2, 5 and 6 read 0x00000000, the page byte is 0x00 and rd_valid is low.
- R2: Coefficient k occupies the aligned group of four bytes at base 0x08, 0x0C, 0x18, 0x1C, 0x48, 0x4C or 0x50 (k = 0..6). Byte offset 0 maps to bits [31:24] and offset 3 maps to bits [7:0]. coef_o carries coefficient k at bits [32k+31:32k].
- R3: Four writes to offsets 0, 1, 2 and 3 of one group, with no other write between them, replace that coefficient. The new value is visible on coef_o after the clock edge that takes the offset-3 byte. Until then the coefficient keeps its old value. A new offset-0 write always starts a fresh sequence.
- R4: Writes to offsets 1 to 3 that were not preceded by an offset-0 write of the same group leave the coefficient unchanged.
- R5: A write to any other address, whether another group, the page byte or an unmapped address, cancels a sequence in progress. The coefficient is then unchanged even if the remaining bytes follow.
- R6: A repeated or skipped offset inside a sequence cancels it, and the coefficient is unchanged.
- R7: Reading an address outside the page byte and the seven groups returns 0x00. Writing such an address has no effect on any readable state.
- R8: A read burst with rd_spi high returns 0x00 for its first request. Each later request returns the byte at rd_addr, then rd_addr+1, and so on.
- R9: A read burst with rd_spi low returns the byte at rd_addr for its first request, then at successive addresses.
- R10: Writing address 0x00 sets the page byte, which is driven on page_o and read back at 0x00. No other write changes it.
- R11: rd_valid is high in exactly the cycle after a cycle with rd_en high, and rd_data is valid then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Byte read request |
| rd_first | input | 1 | Marks the first request of a read burst; rd_addr is taken then |
| rd_spi | input | 1 | Burst comes from the SPI path (leading filler byte) |
| rd_addr | input | 8 | Start address of a read burst |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | rd_data holds a response |
| page_o | output | 8 | Page-select byte |
| coef_o | output | 224 | Seven live coefficients, 32 bits each |

## Verification
The case that is hardest to reach from the ports is a staged sequence that stops partway, with the live value held while the staging register already contains new bytes. It is followed by a second sequence that must either commit cleanly or be dropped. The stimulus interleaves top-byte writes of two groups, slips in writes to unmapped and page addresses, and repeats and skips offsets. Each time it checks coef_o before and after the would-be final byte. Read bursts that run across a group boundary into unmapped space, on both the SPI and the plain path, confirm the byte order and the filler byte.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int CW    = 32;
  localparam int NCOEF = 7;
  localparam int BPC   = CW / DW;
  localparam int BW    = $clog2(BPC);
  localparam int IW    = $clog2(NCOEF);

  // Group bases must be aligned to BPC bytes.
  localparam logic [AW-1:0] GRP_BASE [NCOEF] =
    '{8'h08, 8'h0C, 8'h18, 8'h1C, 8'h48, 8'h4C, 8'h50};
  localparam logic [CW-1:0] GRP_RST [NCOEF] =
    '{32'h7FFF_FFFF, 32'h0, 32'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0};

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
    logic [BW-1:0] bsel;
  } slot_t;

  function automatic slot_t slot_of(input logic [AW-1:0] a);
    slot_t s;
    s = '0;
    for (int i = 0; i < NCOEF; i++) begin
      if (a[AW-1:BW] == GRP_BASE[i][AW-1:BW]) begin
        s.hit = 1'b1;
        s.idx = IW'(i);
      end
    end
    s.bsel = a[BW-1:0];
    return s;
  endfunction
endpackage

// File: rtl/coef_addr_dec.sv
module coef_addr_dec
  import coef_pkg::*;
(
  input  logic [AW-1:0] addr,
  output slot_t         slot,
  output logic          is_page
);
  always_comb begin
    slot    = slot_of(addr);
    is_page = (addr == '0);
  end
endmodule

// File: rtl/coef_wr_seq.sv
module coef_wr_seq
  import coef_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  slot_t             slot,
  input  logic [DW-1:0]     wdata,
  output logic [NCOEF*CW-1:0] live_flat
);
  logic [CW-1:0] live [NCOEF];
  logic [DW-1:0] stage [BPC-1];
  logic          seq_on;
  logic [IW-1:0] seq_idx;
  logic [BW-1:0] seq_next;
  logic [CW-1:0] cand;
  logic          in_order;

  always_comb begin
    cand = '0;
    for (int k = 0; k < BPC-1; k++)
      cand[CW-1-k*DW -: DW] = stage[k];
    cand[DW-1:0] = wdata;
    in_order = slot.hit && seq_on && (slot.idx == seq_idx) && (slot.bsel == seq_next);
  end

  // Staging bytes carry no reset: only a committed value is observable.
  always_ff @(posedge clk) begin
    if (wr_en && slot.hit && (slot.bsel != BW'(BPC-1)))
      stage[int'(slot.bsel)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_on   <= 1'b0;
      seq_idx  <= '0;
      seq_next <= '0;
      for (int i = 0; i < NCOEF; i++) live[i] <= GRP_RST[i];
    end else if (wr_en) begin
      if (slot.hit && slot.bsel == '0) begin
        seq_on   <= 1'b1;
        seq_idx  <= slot.idx;
        seq_next <= BW'(1);
      end else if (in_order) begin
        if (slot.bsel == BW'(BPC-1)) begin
          live[slot.idx] <= cand;
          seq_on         <= 1'b0;
        end else begin
          seq_next <= seq_next + BW'(1);
        end
      end else begin
        seq_on <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NCOEF; g++) begin : g_flat
    assign live_flat[g*CW +: CW] = live[g];
  end
endmodule

// File: rtl/coef_rd_port.sv
module coef_rd_port
  import coef_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic                rd_first,
  input  logic                rd_spi,
  input  logic [AW-1:0]       rd_addr,
  input  logic [NCOEF*CW-1:0] live_flat,
  input  logic [DW-1:0]       page,
  output logic [DW-1:0]       rd_data,
  output logic                rd_valid
);
  logic [AW-1:0] ptr;
  logic [AW-1:0] cur;
  logic [DW-1:0] val;
  logic          filler;
  slot_t         s;
  logic          s_page;

  assign cur    = rd_first ? rd_addr : ptr;
  assign filler = rd_first && rd_spi;

  coef_addr_dec u_dec (.addr(cur), .slot(s), .is_page(s_page));

  always_comb begin
    if (s_page)     val = page;
    else if (s.hit) val = live_flat[int'(s.idx)*CW + (BPC-1-int'(s.bsel))*DW +: DW];
    else            val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ptr      <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= filler ? '0 : val;
        ptr     <= filler ? rd_addr : AW'(cur + AW'(1));
      end
    end
  end
endmodule

// File: rtl/coef_bank.sv
module coef_bank
  import coef_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                rd_en,
  input  logic                rd_first,
  input  logic                rd_spi,
  input  logic [7:0]          rd_addr,
  output logic [7:0]          rd_data,
  output logic                rd_valid,
  output logic [7:0]          page_o,
  output logic [NCOEF*CW-1:0] coef_o
);
  slot_t wslot;
  logic  w_page;

  coef_addr_dec u_wdec (.addr(wr_addr), .slot(wslot), .is_page(w_page));

  coef_wr_seq u_wseq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .slot(wslot),
    .wdata(wr_data), .live_flat(coef_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                  page_o <= '0;
    else if (wr_en && w_page) page_o <= wr_data;
  end

  coef_rd_port u_rport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_first(rd_first), .rd_spi(rd_spi),
    .rd_addr(rd_addr), .live_flat(coef_o), .page(page_o),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/coef_bank_chk.sv
module coef_bank_chk (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [7:0]   wr_addr,
  input logic         rd_en,
  input logic         rd_first,
  input logic         rd_spi,
  input logic [7:0]   rd_addr,
  input logic [7:0]   rd_data,
  input logic         rd_valid,
  input logic [7:0]   page_o,
  input logic [223:0] coef_o
);
  // R11
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R11
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R8
  spi_filler_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_first && rd_spi) |=> (rd_data == 8'h00));
  // R7
  hole_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_first && !rd_spi && rd_addr >= 8'h20 && rd_addr <= 8'h47) |=> (rd_data == 8'h00));
  // R3
  commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(coef_o) || ($past(wr_en) && (($past(wr_addr) & 8'h03) == 8'h03))));
  // R10
  page_write_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(page_o) || ($past(wr_en) && $past(wr_addr) == 8'h00)));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rd_valid && page_o == 8'h00));
endmodule

bind coef_bank coef_bank_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_first(rd_first), .rd_spi(rd_spi), .rd_addr(rd_addr),
  .rd_data(rd_data), .rd_valid(rd_valid), .page_o(page_o), .coef_o(coef_o)
);

// File: tb/coef_bank_bench.sv
module coef_bank_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0, rd_first = 1'b0, rd_spi = 1'b0;
  logic [7:0]   wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0]   rd_data, page_o;
  logic         rd_valid;
  logic [223:0] coef_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] exp_coef [7];
  logic [7:0]  exp_page;
  logic [7:0]  bases [7] = '{8'h08, 8'h0C, 8'h18, 8'h1C, 8'h48, 8'h4C, 8'h50};

  logic [7:0] sb_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  coef_bank u_coef_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_first(rd_first), .rd_spi(rd_spi), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .page_o(page_o), .coef_o(coef_o)
  );

  function automatic logic [7:0] model_byte(input logic [7:0] a);
    if (a == 8'h00) return exp_page;
    for (int i = 0; i < 7; i++)
      if (a >= bases[i] && a < bases[i] + 8'd4)
        return exp_coef[i][31 - 8*(a - bases[i]) -: 8];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read bytes as responses appear.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb_q.size() == 0) check("R11 unexpected rd_valid", 32'(rd_valid), 32'h0);
      else begin
        logic [7:0] e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_burst(input logic [7:0] a, input bit spi, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_en = 1'b1; rd_first = (k == 0); rd_spi = spi; rd_addr = a;
      if (spi && k == 0) sb_q.push_back(8'h00);
      else sb_q.push_back(model_byte(8'(a + (spi ? k - 1 : k))));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_en = 1'b0; rd_first = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_coef(input int i, input string tag);
    @(negedge clk);
    check(tag, coef_o[i*32 +: 32], exp_coef[i]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    exp_coef = '{32'h7FFF_FFFF, 32'h0, 32'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0};
    exp_page = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 7; i++) chk_coef(i, "R1 reset coef");
    check("R1 reset page", 32'(page_o), 32'h0);
    check("R1 reset rd_valid", 32'(rd_valid), 32'h0);

    // R2 R9 plain reads, MSB at lowest address
    rd_burst(8'h08, 1'b0, 4, "R2 R9 read mix A1");
    rd_burst(8'h48, 1'b0, 4, "R2 R9 read iir n0");
    rd_burst(8'h4C, 1'b0, 4, "R9 read iir n1");
    // R8 SPI read with filler byte
    rd_burst(8'h1C, 1'b1, 5, "R8 spi read mix B2");

    // R3 ordered commit, value held until the last byte
    wr(8'h0C, 8'h12); wr(8'h0D, 8'h34); wr(8'h0E, 8'h56);
    chk_coef(1, "R3 held before last byte");
    wr(8'h0F, 8'h78);
    exp_coef[1] = 32'h1234_5678;
    chk_coef(1, "R3 commit");
    rd_burst(8'h0C, 1'b1, 5, "R8 R2 spi readback");

    // R4 sequence without MSB
    wr(8'h19, 8'h01); wr(8'h1A, 8'h02); wr(8'h1B, 8'h03);
    chk_coef(2, "R4 no msb");

    // R5 interrupted by another group, by unmapped, by page
    wr(8'h08, 8'hAA); wr(8'h0C, 8'hBB); wr(8'h09, 8'h01); wr(8'h0A, 8'h02); wr(8'h0B, 8'h03);
    chk_coef(0, "R5 other group");
    chk_coef(1, "R5 second group broken");
    wr(8'h50, 8'h11); wr(8'h20, 8'h99); wr(8'h51, 8'h22); wr(8'h52, 8'h33); wr(8'h53, 8'h44);
    chk_coef(6, "R5 unmapped write breaks");
    wr(8'h50, 8'h11); wr(8'h51, 8'h22); wr(8'h00, 8'h00); wr(8'h52, 8'h33); wr(8'h53, 8'h44);
    chk_coef(6, "R5 page write breaks");

    // R6 repeated and skipped offsets
    wr(8'h48, 8'h01); wr(8'h49, 8'h02); wr(8'h49, 8'h03); wr(8'h4A, 8'h04); wr(8'h4B, 8'h05);
    chk_coef(4, "R6 repeat");
    wr(8'h4C, 8'h01); wr(8'h4E, 8'h02); wr(8'h4F, 8'h03);
    chk_coef(5, "R6 skip");

    // R3 restart by a new MSB write
    wr(8'h48, 8'h11); wr(8'h48, 8'h22); wr(8'h49, 8'h33); wr(8'h4A, 8'h44); wr(8'h4B, 8'h55);
    exp_coef[4] = 32'h2233_4455;
    chk_coef(4, "R3 restart commit");
    rd_burst(8'h48, 1'b0, 4, "R3 R9 readback n0");

    // R7 unmapped
    wr(8'h30, 8'h5A);
    rd_burst(8'h30, 1'b0, 1, "R7 unmapped read");
    rd_burst(8'h10, 1'b1, 5, "R7 R8 unmapped spi");
    rd_burst(8'h0E, 1'b0, 4, "R7 R9 cross boundary");
    for (int i = 0; i < 7; i++) chk_coef(i, "R7 coef untouched");
    check("R7 page untouched", 32'(page_o), 32'(exp_page));

    // R10 page byte
    wr(8'h00, 8'h03);
    exp_page = 8'h03;
    @(negedge clk);
    check("R10 page_o", 32'(page_o), 32'h03);
    rd_burst(8'h00, 1'b0, 2, "R10 page read");

    // R11 no response when idle
    @(negedge clk);
    check("R11 idle rd_valid", 32'(rd_valid), 32'h0);
    check("R11 scoreboard drained", 32'(sb_q.size()), 32'h0);

    finish_run();
  end
endmodule